// File: doc/BRIEF.md
# TMR Vote and Rollback Controller

This block sits beside three processor lanes that run the same program in lockstep. Each time the lanes commit a store-word, it compares their store address and data. When all three agree, the block forwards the store to data memory. When exactly one lane is wrong, the block writes the majority value to memory. It hands the same value back to the faulty lane for repair, then releases a replay so the lanes repeat the faulting instruction. When no two lanes agree, the block writes nothing. It pulses a rollback, which resets every lane and restores it from the newest complete checkpoint.

Checkpoints use the same vote path. The lanes present the words of a save/restore point one at a time, and the final word carries the loop counter. The words go into the checkpoint bank that does not hold the current valid checkpoint. The valid bank pointer moves only after the final word is accepted without a three-way error. A three-way error in the middle of creation abandons the partial checkpoint. The rollback then restores the previous checkpoint, and the lanes re-create the failed checkpoint during re-execution.

Top module: `tmr_rb_ctrl`

## Requirements
- R1: A store commit with all three lanes agreeing drives `dmem_we` high one cycle later, with that address and data. There is no error pulse.
- R2: A commit or checkpoint word in which exactly one lane differs drives `err_a` high for one cycle. In the same cycle `fault_lane` has bit i set for odd lane i (bit 0 = lane 0), and a commit is written to `dmem_*` with the majority value.
- R3: In the `err_a` cycle, `fix_we` is high and `fix_data` holds the majority data. `replay` pulses high exactly one cycle later, and only then.
- R4: A commit or checkpoint word in which all three lanes differ drives `err_b` and `rollback` high for one cycle. It produces no memory or checkpoint write, and `fault_lane` is 0.
- R5: The cycle after any `err_a` or `err_b` is a hold cycle. Store commits and checkpoint words presented in that cycle are ignored: no write and no error.
- R6: An accepted checkpoint word is written through `ckm_*` with the majority data. The slot counts up from 0 within one creation. The bank is the inverse of `ckpt_bank`.
- R7: After reset, `ckpt_ok` = 0 and `ckpt_bank` = 0. Only an accepted final word (`ck_last`) with no three-way error sets `ckpt_ok` and flips `ckpt_bank`. This happens in the same cycle as that word's `ckm_we`.
- R8: A three-way error during checkpoint creation, including on the loop-counter word, leaves `ckpt_ok` and `ckpt_bank` unchanged. The next creation restarts at slot 0.
- R9: When `st_commit` and `ck_word` are both high, the commit is handled and the checkpoint word is ignored.
- R10: While reset is asserted, and after it is released, every output is 0 until the first accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_commit | input | 1 | Lanes commit a store-word this cycle |
| ck_word | input | 1 | Lanes present a checkpoint word this cycle |
| ck_last | input | 1 | Checkpoint word is the final (loop-counter) word |
| l0_addr | input | AW | Lane 0 address |
| l0_data | input | DW | Lane 0 data |
| l1_addr | input | AW | Lane 1 address |
| l1_data | input | DW | Lane 1 data |
| l2_addr | input | AW | Lane 2 address |
| l2_data | input | DW | Lane 2 data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | AW | Voted store address |
| dmem_wdata | output | DW | Voted store data |
| ckm_we | output | 1 | Checkpoint memory write strobe |
| ckm_bank | output | 1 | Checkpoint bank being written |
| ckm_slot | output | SW | Word slot within the checkpoint |
| ckm_wdata | output | DW | Voted checkpoint word |
| ckpt_ok | output | 1 | A complete checkpoint exists |
| ckpt_bank | output | 1 | Bank holding the valid checkpoint |
| err_a | output | 1 | Single-lane mismatch pulse |
| err_b | output | 1 | Three-way mismatch pulse |
| fault_lane | output | 3 | One-hot faulty lane for a single-lane mismatch |
| fix_we | output | 1 | Write majority value back into the faulty lane |
| fix_data | output | DW | Majority data for the repair |
| replay | output | 1 | Release lanes to repeat the faulting instruction |
| rollback | output | 1 | Reset all lanes and restore from `ckpt_bank` |

## Verification
Each result appears one rising edge after the inputs are sampled. Writes, error pulses, fault lane, repair and rollback all appear then. The checkpoint valid flag and bank pointer update at that same edge. `replay` follows one edge later, and the hold cycle spans that second edge. The bench drives each stimulus on a falling edge and steps a reference model. It compares every output at the next falling edge, so each comparison lands exactly one register stage after its stimulus. The replay and hold effects show up naturally in the following step.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  typedef enum logic [1:0] {
    VOTE_AGREE   = 2'd0,
    VOTE_ONE_OFF = 2'd1,
    VOTE_SPLIT   = 2'd2
  } vote_e;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;
endpackage

// File: rtl/tmr_rb_voter.sv
module tmr_rb_voter
  import tmr_rb_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [2:0][W-1:0] lanes,
  output vote_e             kind,
  output logic [2:0]        odd,
  output logic [W-1:0]      major
);
  // A lane is odd when its two neighbours agree with each other but not with it.
  for (genvar g = 0; g < 3; g++) begin : g_odd
    localparam int J = (g + 1) % 3;
    localparam int K = (g + 2) % 3;
    assign odd[g] = (lanes[J] == lanes[K]) && (lanes[g] != lanes[J]);
  end

  always_comb begin
    if (odd == 3'b000 && lanes[0] == lanes[1]) kind = VOTE_AGREE;
    else if (|odd)                             kind = VOTE_ONE_OFF;
    else                                       kind = VOTE_SPLIT;
  end

  assign major = ((lanes[0] == lanes[1]) || (lanes[0] == lanes[2])) ? lanes[0] : lanes[1];
endmodule

// File: rtl/tmr_rb_ckpt.sv
module tmr_rb_ckpt #(
  parameter int NSLOT = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_ok,
  input  logic          last,
  input  logic          abort,
  output logic [SW-1:0] slot,
  output logic          wbank,
  output logic          vbank,
  output logic          vok
);
  logic [SW-1:0] slot_q, slot_d;
  logic          bank_q, bank_d;
  logic          ok_q, ok_d;

  always_comb begin
    slot_d = slot_q;
    bank_d = bank_q;
    ok_d   = ok_q;
    if (abort) begin
      slot_d = '0;
    end else if (word_ok) begin
      if (last) begin
        slot_d = '0;
        bank_d = ~bank_q;
        ok_d   = 1'b1;
      end else if (slot_q == SW'(NSLOT - 1)) begin
        slot_d = '0;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bank_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      bank_q <= bank_d;
      ok_q   <= ok_d;
    end
  end

  assign slot  = slot_q;
  assign wbank = ~bank_q;
  assign vbank = bank_q;
  assign vok   = ok_q;

  // R8: an abandoned creation never moves the valid pointer
  p_abort_keeps_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (vbank == $past(vbank)) && (vok == $past(vok)));
  // R6: slot stays within the checkpoint size
  p_slot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SW'(NSLOT - 1));
endmodule

// File: rtl/tmr_rb_ctrl.sv
module tmr_rb_ctrl
  import tmr_rb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NSLOT = 8,
  localparam int W  = AW + DW,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_commit,
  input  logic          ck_word,
  input  logic          ck_last,
  input  logic [AW-1:0] l0_addr,
  input  logic [DW-1:0] l0_data,
  input  logic [AW-1:0] l1_addr,
  input  logic [DW-1:0] l1_data,
  input  logic [AW-1:0] l2_addr,
  input  logic [DW-1:0] l2_data,
  output logic          dmem_we,
  output logic [AW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          ckm_we,
  output logic          ckm_bank,
  output logic [SW-1:0] ckm_slot,
  output logic [DW-1:0] ckm_wdata,
  output logic          ckpt_ok,
  output logic          ckpt_bank,
  output logic          err_a,
  output logic          err_b,
  output logic [2:0]    fault_lane,
  output logic          fix_we,
  output logic [DW-1:0] fix_data,
  output logic          replay,
  output logic          rollback
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // vote
  logic [2:0][W-1:0] lanes;
  vote_e             kind;
  logic [2:0]        odd;
  logic [W-1:0]      major;
  assign lanes = {{l2_addr, l2_data}, {l1_addr, l1_data}, {l0_addr, l0_data}};

  tmr_rb_voter #(.W(W)) u_voter (
    .lanes(lanes), .kind(kind), .odd(odd), .major(major)
  );

  // acceptance
  phase_e ph_q, ph_d;
  logic   pend_a_q, pend_a_d;
  logic   take_st, take_ck, take_any, one_off, split;
  assign take_st  = (ph_q == PH_RUN) && st_commit;
  assign take_ck  = (ph_q == PH_RUN) && ck_word && !st_commit;
  assign take_any = take_st || take_ck;
  assign one_off  = take_any && (kind == VOTE_ONE_OFF);
  assign split    = take_any && (kind == VOTE_SPLIT);

  // checkpoint sequencing
  logic [SW-1:0] slot;
  logic          wbank;
  tmr_rb_ckpt #(.NSLOT(NSLOT)) u_ckpt (
    .clk(clk), .rst_n(rst_s_n),
    .word_ok(take_ck && !split), .last(ck_last), .abort(split),
    .slot(slot), .wbank(wbank), .vbank(ckpt_bank), .vok(ckpt_ok)
  );

  // next-state for registered outputs
  logic          dmem_we_d, ckm_we_d, err_a_d, err_b_d, fix_we_d, replay_d, rollback_d;
  logic [2:0]    fault_d;
  logic [SW-1:0] slot_d;
  logic          bank_d;

  always_comb begin
    dmem_we_d  = take_st && !split;
    ckm_we_d   = take_ck && !split;
    err_a_d    = one_off;
    err_b_d    = split;
    fault_d    = one_off ? odd : 3'b000;
    fix_we_d   = one_off;
    rollback_d = split;
    replay_d   = (ph_q == PH_HOLD) && pend_a_q;
    slot_d     = slot;
    bank_d     = wbank;
    ph_d       = (one_off || split) ? PH_HOLD : PH_RUN;
    pend_a_d   = one_off;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q       <= PH_RUN;
      pend_a_q   <= 1'b0;
      dmem_we    <= 1'b0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
      ckm_we     <= 1'b0;
      ckm_bank   <= 1'b0;
      ckm_slot   <= '0;
      ckm_wdata  <= '0;
      err_a      <= 1'b0;
      err_b      <= 1'b0;
      fault_lane <= 3'b000;
      fix_we     <= 1'b0;
      fix_data   <= '0;
      replay     <= 1'b0;
      rollback   <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      pend_a_q   <= pend_a_d;
      dmem_we    <= dmem_we_d;
      ckm_we     <= ckm_we_d;
      err_a      <= err_a_d;
      err_b      <= err_b_d;
      fault_lane <= fault_d;
      fix_we     <= fix_we_d;
      replay     <= replay_d;
      rollback   <= rollback_d;
      if (dmem_we_d) begin
        dmem_addr  <= major[W-1:DW];
        dmem_wdata <= major[DW-1:0];
      end
      if (ckm_we_d) begin
        ckm_bank  <= bank_d;
        ckm_slot  <= slot_d;
        ckm_wdata <= major[DW-1:0];
      end
      if (fix_we_d) fix_data <= major[DW-1:0];
    end
  end

  // R2: fault indicator is one-hot or idle
  p_fault_onehot_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(fault_lane));
  // R2: a named lane only comes with a single-lane error
  p_fault_with_a_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fault_lane != 3'b000) |-> err_a);
  // R3: repair is followed by replay, and replay has a repair before it
  p_replay_after_fix_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    fix_we |=> replay);
  p_replay_cause_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    replay |-> $past(fix_we));
  // R4: rollback writes nothing
  p_rollback_no_write_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    rollback |-> !dmem_we && !ckm_we && !err_a);
  // R5: the cycle after an error is quiet
  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (err_a || err_b) |=> !dmem_we && !ckm_we && !err_a && !err_b);
  // R7: validity only rises with a checkpoint write
  p_valid_with_write_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ckpt_ok) |-> ckm_we);
  // R8: three-way error leaves the valid pointer alone
  p_split_keeps_bank_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_b |-> $stable(ckpt_bank) && $stable(ckpt_ok));
endmodule

// File: tb/tmr_rb_ctrl_tb.sv
module tmr_rb_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NSLOT = 8;
  localparam int W  = AW + DW;
  localparam int SW = $clog2(NSLOT);

  logic clk = 1'b0;
  logic rst_n;
  logic st_commit, ck_word, ck_last;
  logic [AW-1:0] l0_addr, l1_addr, l2_addr;
  logic [DW-1:0] l0_data, l1_data, l2_data;
  logic dmem_we, ckm_we, ckm_bank, ckpt_ok, ckpt_bank, err_a, err_b, fix_we, replay, rollback;
  logic [AW-1:0] dmem_addr;
  logic [DW-1:0] dmem_wdata, ckm_wdata, fix_data;
  logic [SW-1:0] ckm_slot;
  logic [2:0] fault_lane;

  always #10 clk = ~clk;

  tmr_rb_ctrl #(.AW(AW), .DW(DW), .NSLOT(NSLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_commit(st_commit), .ck_word(ck_word), .ck_last(ck_last),
    .l0_addr(l0_addr), .l0_data(l0_data), .l1_addr(l1_addr), .l1_data(l1_data),
    .l2_addr(l2_addr), .l2_data(l2_data),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .ckm_we(ckm_we), .ckm_bank(ckm_bank), .ckm_slot(ckm_slot), .ckm_wdata(ckm_wdata),
    .ckpt_ok(ckpt_ok), .ckpt_bank(ckpt_bank), .err_a(err_a), .err_b(err_b),
    .fault_lane(fault_lane), .fix_we(fix_we), .fix_data(fix_data),
    .replay(replay), .rollback(rollback)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit m_hold, m_pend, m_bank, m_ok;
  int m_slot;

  function automatic int vkind(logic [2:0][W-1:0] lw);
    int n;
    n = int'(lw[0] == lw[1]) + int'(lw[0] == lw[2]) + int'(lw[1] == lw[2]);
    return (n == 3) ? 0 : (n == 1) ? 1 : 2;
  endfunction

  function automatic logic [2:0] vodd(logic [2:0][W-1:0] lw);
    logic [2:0] r;
    r[0] = (lw[1] == lw[2]) && (lw[0] != lw[1]);
    r[1] = (lw[0] == lw[2]) && (lw[1] != lw[0]);
    r[2] = (lw[0] == lw[1]) && (lw[2] != lw[0]);
    return r;
  endfunction

  function automatic logic [W-1:0] vmaj(logic [2:0][W-1:0] lw);
    return (lw[1] == lw[2]) ? lw[1] : lw[0];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit k, input bit l, input logic [2:0][W-1:0] lw, input string ctx);
    int  kd;
    bit  tst, tck, ea, eb, ewe, cwe, rp;
    logic [W-1:0] mj;
    int  eslot;
    bit  ebank;
    st_commit = c; ck_word = k; ck_last = l;
    {l0_addr, l0_data} = lw[0];
    {l1_addr, l1_data} = lw[1];
    {l2_addr, l2_data} = lw[2];
    kd  = vkind(lw);
    mj  = vmaj(lw);
    tst = !m_hold && c;
    tck = !m_hold && k && !c;
    ea  = (tst || tck) && kd == 1;
    eb  = (tst || tck) && kd == 2;
    ewe = tst && kd != 2;
    cwe = tck && kd != 2;
    rp  = m_hold && m_pend;
    eslot = m_slot;
    ebank = !m_bank;
    if (cwe) begin
      if (l) begin m_slot = 0; m_bank = !m_bank; m_ok = 1'b1; end
      else m_slot = (m_slot == NSLOT - 1) ? 0 : m_slot + 1;
    end
    if (eb) m_slot = 0;
    m_hold = ea || eb;
    m_pend = ea;
    @(posedge clk);
    @(negedge clk);
    chk({"R1 ", ctx}, "dmem_we", 32'(dmem_we), 32'(ewe));
    if (ewe) begin
      chk({"R1 ", ctx}, "dmem_addr", 32'(dmem_addr), 32'(mj[W-1:DW]));
      chk({"R2 ", ctx}, "dmem_wdata", 32'(dmem_wdata), 32'(mj[DW-1:0]));
    end
    chk({"R2 ", ctx}, "err_a", 32'(err_a), 32'(ea));
    chk({"R2 ", ctx}, "fault_lane", 32'(fault_lane), 32'(ea ? vodd(lw) : 3'b000));
    chk({"R3 ", ctx}, "fix_we", 32'(fix_we), 32'(ea));
    if (ea) chk({"R3 ", ctx}, "fix_data", 32'(fix_data), 32'(mj[DW-1:0]));
    chk({"R3 ", ctx}, "replay", 32'(replay), 32'(rp));
    chk({"R4 ", ctx}, "err_b", 32'(err_b), 32'(eb));
    chk({"R4 ", ctx}, "rollback", 32'(rollback), 32'(eb));
    chk({"R6 ", ctx}, "ckm_we", 32'(ckm_we), 32'(cwe));
    if (cwe) begin
      chk({"R6 ", ctx}, "ckm_slot", 32'(ckm_slot), 32'(eslot));
      chk({"R6 ", ctx}, "ckm_bank", 32'(ckm_bank), 32'(ebank));
      chk({"R6 ", ctx}, "ckm_wdata", 32'(ckm_wdata), 32'(mj[DW-1:0]));
    end
    chk({"R7 ", ctx}, "ckpt_ok", 32'(ckpt_ok), 32'(m_ok));
    chk({"R7 ", ctx}, "ckpt_bank", 32'(ckpt_bank), 32'(m_bank));
  endtask

  function automatic logic [2:0][W-1:0] same(logic [W-1:0] v);
    return {v, v, v};
  endfunction

  function automatic logic [2:0][W-1:0] one_bad(logic [W-1:0] v, int lane);
    logic [2:0][W-1:0] r;
    r = {v, v, v};
    r[lane] = v ^ (W'(1) << ($urandom % W));
    return r;
  endfunction

  function automatic logic [2:0][W-1:0] all_bad(logic [W-1:0] v);
    logic [2:0][W-1:0] r;
    int b;
    b = $urandom % (W - 1);
    r[0] = v;
    r[1] = v ^ (W'(1) << b);
    r[2] = v ^ (W'(1) << (b + 1));
    return r;
  endfunction

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    st_commit = 0; ck_word = 0; ck_last = 0;
    l0_addr = '0; l1_addr = '0; l2_addr = '0;
    l0_data = '0; l1_data = '0; l2_data = '0;
    m_hold = 0; m_pend = 0; m_bank = 0; m_ok = 0; m_slot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: quiet outputs after reset
    chk("R10", "outputs", 32'({dmem_we, ckm_we, err_a, err_b, fault_lane, fix_we, replay, rollback, ckpt_ok, ckpt_bank}), 32'h0);

    step(1, 0, 0, same(24'h12_3456), "agree commit");
    step(1, 0, 0, one_bad(24'h20_1111, 0), "lane0 odd");
    // R5: mismatching commit during hold is ignored; replay seen here (R3)
    step(1, 0, 0, all_bad(24'h20_2222), "R5 hold after A");
    step(1, 0, 0, one_bad(24'h21_3333, 1), "lane1 odd");
    step(0, 0, 0, same('0), "replay cycle");
    step(1, 0, 0, one_bad(24'h22_4444, 2), "lane2 odd");
    step(0, 0, 0, same('0), "replay cycle");
    step(1, 0, 0, all_bad(24'h30_5555), "split commit");
    step(1, 0, 0, same(24'h30_6666), "R5 hold after B");
    // R6/R7: a full checkpoint into bank 1
    step(0, 1, 0, same(24'h00_0a0a), "ckpt w0");
    step(0, 1, 0, one_bad(24'h01_0b0b, 1), "ckpt w1 one odd");
    step(0, 0, 0, same('0), "replay cycle");
    step(0, 1, 0, same(24'h02_0c0c), "ckpt w2");
    step(0, 1, 1, same(24'h03_00fa), "ckpt loop counter");
    // R8: split on loop-counter word abandons creation
    step(0, 1, 0, same(24'h00_1a1a), "ckpt2 w0");
    step(0, 1, 1, all_bad(24'h01_01f4), "R8 split on loop counter");
    step(0, 0, 0, same('0), "R8 hold");
    step(0, 1, 0, same(24'h00_1b1b), "R8 restart slot 0");
    step(0, 1, 1, same(24'h01_01f4), "R8 recreate");
    // R9: commit wins over checkpoint word
    step(1, 1, 0, same(24'h44_7777), "R9 both high");

    for (int i = 0; i < 3000; i++) begin
      int r, p;
      bit c, k, l;
      logic [W-1:0] v;
      logic [2:0][W-1:0] lw;
      r = $urandom % 16;
      c = (r < 7) || (r == 15);
      k = (r >= 7 && r < 13) || (r == 15);
      l = k && ($urandom % 4 == 0);
      v = W'($urandom);
      p = $urandom % 8;
      if (p < 5)       lw = same(v);
      else if (p < 7)  lw = one_bad(v, $urandom % 3);
      else             lw = all_bad(v);
      step(c, k, l, lw, "random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule